// File: doc/BRIEF.md
# Programmable Bit Clock Recovery

This block rebuilds a bit clock from a serial data stream that has already been demodulated and is sampled on a fast base clock. Two configuration inputs set its behaviour. One is the nominal bit period, counted in whole base clock cycles. The other is a correction step, also counted in base cycles. When reception is enabled, the block counts a phase from bit start up to the end of the bit and produces a free-running recovered clock at the nominal period. The clock rises at the middle of each bit.

Each transition of the synchronized data input moves the phase by the correction step. A transition in the first half of the bit pushes the next clock edge later. A transition in the second half pulls it earlier. A transition seen exactly at bit start leaves the phase alone. Retimed data is captured on every rising edge of the recovered clock.

A larger step reaches the correct phase in fewer transitions but adds more jitter. A smaller step may fail to follow a transmitter whose rate differs from the programmed period, so a small step requires transitions that arrive more often.

Top module: `bitclk_recovery`

## Requirements
- R1: While reset is asserted, and at the first sample after it is released, `recClk` and `recData` are 0.
- R2: When `rxEn` is 0, or `bitPeriod` is below 2, or `stepSize` is 0, the block is idle. In that state `recClk` is 0, `recData` holds its value, and the phase returns to 0. Once the block leaves idle, the first rising edge of `recClk` appears floor(P/2) base cycles later, where P is `bitPeriod`.
- R3: With no data transitions, `recClk` has a period of exactly P cycles and is high for P − floor(P/2) cycles of each period. It is high exactly while the phase, which counts base cycles from bit start over the range 0..P−1, is at least floor(P/2).
- R4: The `recClk` output is the internal clock gated by `clkOutEn`. It toggles whenever `clkOutEn` is 1 and the block is not idle, whether or not the data input changes.
- R5: `rxData` passes through two synchronizer stages and then an edge comparator. A change is acted on at the third rising base clock edge after it settles, using the phase held just before that edge.
- R6: A transition seen at phase 1..floor(P/2)−1 sets the next phase to max(phase+1−step, 0). This delays the clock.
- R7: A transition seen at phase floor(P/2)..P−1 sets the next phase to phase+1+step. If that value is P or more, the next phase is 0 instead. This advances the clock.
- R8: A transition seen at phase 0 causes no correction, so the next phase is 1.
- R9: `recData` takes the synchronized data value on the cycle that `recClk` rises, and changes at no other time.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Base clock |
| rstN | input | 1 | Asynchronous reset, active low |
| rxEn | input | 1 | Reception active |
| clkOutEn | input | 1 | Enable for the recovered clock output |
| bitPeriod | input | 14 | Nominal bit period in base cycles |
| stepSize | input | 8 | Phase correction step in base cycles |
| rxData | input | 1 | Demodulated serial data, asynchronous |
| recClk | output | 1 | Recovered bit clock |
| recData | output | 1 | Data retimed on the rising edge of recClk |

## Verification
The hardest states to reach from the ports are the individual correction branches. These are the delay with clamping at zero, the advance that snaps to bit start, and the aligned case with no correction. Each depends on the exact phase at which a transition arrives, and the phase is hidden behind a three-cycle synchronizer delay. The directed stimulus first waits for a rising edge of `recClk`, where the phase is known to be floor(P/2). It then counts base cycles to reach a chosen phase, toggles the data there, and measures the spacing of the next rising edge. Random runs with mismatched transmit rates then compare every cycle against a model built from the requirements.

// File: rtl/bcr_pkg.sv
package bcr_pkg;

  // Strobes from the control to the datapath, decided once per base cycle
  typedef struct packed {
    logic clear;    // idle: force the phase back to bit start
    logic retard;   // transition in the first half: move the clock later
    logic advance;  // transition in the second half: move the clock earlier
  } bcrCtlT;

endpackage

// File: rtl/bcr_edge_sync.sv
module bcr_edge_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic syncD,
  output logic edgeSeen
);

  logic [STAGES-1:0] chain;
  logic prevD;

  generate
    if (STAGES == 1) begin : g_single
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= din;
      end
    end else begin : g_multi
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) chain <= '0;
        else       chain <= {chain[STAGES-2:0], din};
      end
    end
  endgenerate

  assign syncD = chain[STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) prevD <= 1'b0;
    else       prevD <= syncD;
  end

  assign edgeSeen = syncD ^ prevD;

endmodule

// File: rtl/bcr_ctrl.sv
module bcr_ctrl
  import bcr_pkg::*;
#(
  parameter int PER_W  = 14,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEn,
  input  logic [PER_W-1:0]  bitPeriod,
  input  logic [STEP_W-1:0] stepSize,
  input  logic [PER_W-1:0]  phase,
  input  logic              edgeSeen,
  output logic              run,
  output bcrCtlT            ctl
);

  logic [PER_W-1:0] half;
  logic             cfgOk;

  assign half  = bitPeriod >> 1;
  assign cfgOk = (bitPeriod >= PER_W'(2)) && (stepSize != '0);
  assign run   = rxEn && cfgOk;

  always_comb begin
    ctl         = '0;
    ctl.clear   = !run;
    ctl.retard  = run && edgeSeen && (phase != '0) && (phase < half);
    ctl.advance = run && edgeSeen && (phase >= half);
  end

  // R2: an idle cycle sends the phase back to bit start
  p_clear_r2: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> (phase == '0));

  // R8: a transition at bit start leaves the count running normally
  p_aligned_r8: assert property (@(posedge clk) disable iff (!rstN)
    (run && edgeSeen && phase == '0) |=> (phase == PER_W'(1)));

  // R6: a delay never moves the phase forward
  p_retard_r6: assert property (@(posedge clk) disable iff (!rstN)
    ctl.retard |=> (phase <= $past(phase)));

endmodule

// File: rtl/bcr_datapath.sv
module bcr_datapath
  import bcr_pkg::*;
#(
  parameter int PER_W  = 14,
  parameter int STEP_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  bcrCtlT            ctl,
  input  logic              run,
  input  logic [PER_W-1:0]  bitPeriod,
  input  logic [STEP_W-1:0] stepSize,
  input  logic              syncD,
  output logic [PER_W-1:0]  phase,
  output logic              recClkQ,
  output logic              recData
);

  localparam int WIDE  = (PER_W > STEP_W) ? PER_W : STEP_W;
  localparam int SUM_W = WIDE + 2;

  logic [SUM_W-1:0] incr, fwd, back, perExt, stepExt;
  logic [PER_W-1:0] phaseNext, half;
  logic             runQ;

  assign half    = bitPeriod >> 1;
  assign perExt  = SUM_W'(bitPeriod);
  assign stepExt = SUM_W'(stepSize);
  assign incr    = SUM_W'(phase) + SUM_W'(1);
  assign fwd     = incr + stepExt;
  assign back    = (incr >= stepExt) ? (incr - stepExt) : '0;

  always_comb begin
    if (ctl.clear)        phaseNext = '0;
    else if (ctl.advance) phaseNext = (fwd >= perExt) ? '0 : fwd[PER_W-1:0];
    else if (ctl.retard)  phaseNext = back[PER_W-1:0];
    else                  phaseNext = (incr >= perExt) ? '0 : incr[PER_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      phase   <= '0;
      recClkQ <= 1'b0;
      recData <= 1'b0;
      runQ    <= 1'b0;
    end else begin
      phase   <= phaseNext;
      recClkQ <= run && (phaseNext >= half);
      runQ    <= run;
      if (run && phaseNext == half) recData <= syncD;
    end
  end

  // R2: idle drops the clock
  p_idle_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    !run |=> !recClkQ);

  // R3: phase stays inside the bit while running on a steady period
  p_phase_bound_r3: assert property (@(posedge clk) disable iff (!rstN)
    (runQ && $stable(bitPeriod)) |-> (phase < bitPeriod));

  // R7: an advance moves forward or snaps to bit start
  p_advance_r7: assert property (@(posedge clk) disable iff (!rstN)
    ctl.advance |=> ((phase > $past(phase)) || (phase == '0)));

  // R9: retimed data only moves together with a high clock
  p_capture_r9: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(recData) |-> recClkQ);

endmodule

// File: rtl/bitclk_recovery.sv
module bitclk_recovery
  import bcr_pkg::*;
#(
  parameter int PER_W       = 14,
  parameter int STEP_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              rxEn,
  input  logic              clkOutEn,
  input  logic [PER_W-1:0]  bitPeriod,
  input  logic [STEP_W-1:0] stepSize,
  input  logic              rxData,
  output logic              recClk,
  output logic              recData
);

  logic             syncD, edgeSeen, run, recClkQ;
  logic [PER_W-1:0] phase;
  bcrCtlT           ctl;

  bcr_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rstN(rstN), .din(rxData), .syncD(syncD), .edgeSeen(edgeSeen)
  );

  bcr_ctrl #(.PER_W(PER_W), .STEP_W(STEP_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .rxEn(rxEn), .bitPeriod(bitPeriod),
    .stepSize(stepSize), .phase(phase), .edgeSeen(edgeSeen),
    .run(run), .ctl(ctl)
  );

  bcr_datapath #(.PER_W(PER_W), .STEP_W(STEP_W)) u_dp (
    .clk(clk), .rstN(rstN), .ctl(ctl), .run(run), .bitPeriod(bitPeriod),
    .stepSize(stepSize), .syncD(syncD), .phase(phase),
    .recClkQ(recClkQ), .recData(recData)
  );

  assign recClk = recClkQ & clkOutEn;

endmodule

// File: tb/test_bitclk_recovery.sv
module test_bitclk_recovery;
  localparam int CLK_PERIOD = 10;
  localparam int PER_W = 14;
  localparam int STEP_W = 8;

  logic clk, rstN, rxEn, clkOutEn, rxData;
  logic [PER_W-1:0] bitPeriod;
  logic [STEP_W-1:0] stepSize;
  logic recClk, recData;

  bitclk_recovery i_bitclk_recovery (
    .clk(clk), .rstN(rstN), .rxEn(rxEn), .clkOutEn(clkOutEn),
    .bitPeriod(bitPeriod), .stepSize(stepSize), .rxData(rxData),
    .recClk(recClk), .recData(recData)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  int tests = 0, fails = 0, cyc = 0, riseCnt = 0, riseGap = 0, lastRise = 0;
  int mism = 0;
  bit lastClk = 0, cmpOn = 0, done = 0;

  // Reference model written from the requirements
  logic mS1, mS2, mPrev, mClk, mData;
  int mPhase;

  function automatic int modelNext(int ph, bit edg, bit run, int p, int st);
    int h;
    if (!run) return 0;
    h = p / 2;
    if (edg && ph != 0 && ph < h) return (ph + 1 >= st) ? ph + 1 - st : 0;   // R6
    if (edg && ph >= h) return (ph + 1 + st >= p) ? 0 : ph + 1 + st;         // R7
    return (ph + 1 >= p) ? 0 : ph + 1;                                       // R3, R8
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mS1 <= 0; mS2 <= 0; mPrev <= 0; mClk <= 0; mData <= 0; mPhase <= 0;
    end else begin
      bit run;
      int nx;
      run = rxEn && (int'(bitPeriod) >= 2) && (stepSize != 0);
      nx = modelNext(mPhase, mS2 != mPrev, run, int'(bitPeriod), int'(stepSize));
      mS1 <= rxData; mS2 <= mS1; mPrev <= mS2;   // R5
      mPhase <= nx;
      mClk <= run && (nx >= int'(bitPeriod) / 2);
      if (run && nx == int'(bitPeriod) / 2) mData <= mS2;
    end
  end

  task automatic check(bit ok, string req, int act, int exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    cyc++;
    if (recClk && !lastClk) begin
      riseCnt++; riseGap = cyc - lastRise; lastRise = cyc;
    end
    lastClk = recClk;
    if (cmpOn && (recClk !== (mClk & clkOutEn) || recData !== mData)) mism++;
  endtask

  task automatic waitRise();
    int start = riseCnt;
    int guard = 0;
    while (riseCnt == start && guard < 4000) begin tick(); guard++; end
    if (riseCnt == start) check(0, "rise timeout", 0, 1);
  endtask

  task automatic setCfg(int p, int s);
    rxEn = 0;
    repeat (3) tick();
    bitPeriod = PER_W'(p); stepSize = STEP_W'(s);
    tick();
    rxEn = 1;
  endtask

  // toggle the data where the phase equals q, return the next rise spacing
  task automatic edgeAt(int q, output int gap);
    int p = int'(bitPeriod);
    int h = p / 2;
    waitRise();
    repeat ((q - h + p) % p) tick();
    rxData = ~rxData;
    waitRise();
    gap = riseGap;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!done) begin
      check(0, "watchdog", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    int gap, hi, cnt;
    void'($urandom(32'd2024));
    rstN = 0; rxEn = 0; clkOutEn = 1; rxData = 1;
    bitPeriod = 14'd20; stepSize = 8'd3;
    repeat (3) tick();
    check(recClk == 0, "R1 recClk in reset", recClk, 0);
    check(recData == 0, "R1 recData in reset", recData, 0);
    rstN = 1;
    tick();
    check(recClk == 0 && recData == 0, "R1 after release", recClk, 0);

    // R2: idle conditions
    cnt = 0;
    repeat (60) begin rxData = ~rxData; tick(); cnt += recClk; end
    check(cnt == 0, "R2 rxEn low", cnt, 0);
    setCfg(1, 3);
    cnt = 0; repeat (40) begin tick(); cnt += recClk; end
    check(cnt == 0, "R2 period 1", cnt, 0);
    setCfg(20, 0);
    cnt = 0; repeat (60) begin tick(); cnt += recClk; end
    check(cnt == 0, "R2 step 0", cnt, 0);
    check(recData == 0, "R2 recData held", recData, 0);

    // R2: first rise floor(P/2) cycles after leaving idle
    setCfg(20, 3);
    cnt = 0;
    while (!recClk && cnt < 100) begin tick(); cnt++; end
    check(cnt == 10, "R2 first rise delay", cnt, 10);

    // R3: free-running period and high time
    waitRise();
    check(riseGap == 20, "R3 period 20", riseGap, 20);
    hi = 1; repeat (19) begin tick(); hi += recClk; end
    check(hi == 10, "R3 high time 20", hi, 10);
    setCfg(7, 1);
    waitRise(); waitRise();
    check(riseGap == 7, "R3 period 7", riseGap, 7);
    hi = 1; repeat (6) begin tick(); hi += recClk; end
    check(hi == 4, "R3 high time 7", hi, 4);

    // R4: output gating, no data transitions needed
    clkOutEn = 0;
    cnt = 0; repeat (21) begin tick(); cnt += recClk; end
    check(cnt == 0, "R4 gated low", cnt, 0);
    clkOutEn = 1;
    cnt = 0; repeat (21) begin tick(); cnt += recClk; end
    check(cnt > 0, "R4 enabled toggles", cnt, 1);

    // Corrections at known phases, P=20 step=3
    setCfg(20, 3);
    waitRise(); waitRise();
    edgeAt(18, gap); check(gap == 20, "R8 R5 aligned edge", gap, 20);
    edgeAt(0, gap);  check(gap == 23, "R6 delay", gap, 23);
    edgeAt(10, gap); check(gap == 17, "R7 advance", gap, 17);
    setCfg(20, 9);
    waitRise(); waitRise();
    edgeAt(15, gap); check(gap == 18, "R7 snap to start", gap, 18);
    edgeAt(0, gap);  check(gap == 23, "R6 clamp at zero", gap, 23);

    // R9: retimed data
    setCfg(16, 2);
    rxData = 1; waitRise(); waitRise();
    check(recData == 1, "R9 capture one", recData, 1);
    rxData = 0; waitRise(); waitRise();
    check(recData == 0, "R9 capture zero", recData, 0);

    // Random streams against the model (R5 R6 R7 R8 R9)
    for (int k = 0; k < 6; k++) begin
      int p = $urandom_range(80, 8);
      int s = $urandom_range((p / 4 > 1) ? p / 4 : 1, 1);
      int tx = p + $urandom_range(2, 0) - 1;
      setCfg(p, s);
      clkOutEn = $urandom_range(1, 0);
      mism = 0; cmpOn = 1;
      repeat ($urandom_range(p, 1)) tick();
      for (int b = 0; b < 40; b++) begin
        rxData = $urandom_range(1, 0);
        repeat (tx) tick();
      end
      cmpOn = 0;
      check(mism == 0, "R6 R7 R9 random vs model", mism, 0);
      clkOutEn = 1;
    end

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule